// File: doc/BRIEF.md
# Bit-Cell Timed Read Data Shifter

This block turns the serial read stream of a disk drive into bytes. Each flux-transition pulse from the drive counts as a 1 bit. A 0 bit never arrives as a pulse. The block infers a 0 when no pulse has come within a timeout. That timeout is the selected bit-cell length plus two clock cycles. Every inferred or received bit enters the low end of an 8-bit shifter.

A byte has no fixed bit count. It is complete at the moment its top bit turns on. The completed value then moves into a data register that the host can see, and the shifter starts again from zero. When the host reads a completed byte, the register empties, so each byte is seen once.

The controller has two mode-switch lines, a status select and a write select. The shifter works only while both lines are low, which is read mode. In any other mode the bit timer, the shifter and the data register all hold their state.

Top module: `fluxrd_top`

## Requirements
- R1: `cellSel` sets the bit-cell length L in clock cycles: code 0 gives 24, code 1 gives 12, code 2 gives 32 and code 3 gives 16.
- R2: A `fluxPulse` high at a clock edge in read mode shifts a 1 into bit 0 of the shifter and restarts the bit timer from zero.
- R3: When the bit timer has run L+2 cycles since the last shift with no pulse, a 0 is shifted in and the timer restarts. After one pulse and then only silence, `dataOut` becomes 0x80 exactly 7*(L+2) edges after the pulse edge.
- R4: When a shift makes bit 7 of the shifter 1, that value is loaded into the data register at the same edge and the shifter clears to zero.
- R5: `dataOut` shows the data register. A `hostRead` at an edge in read mode while `dataOut[7]` is 1 clears the data register to 0 at that edge. The full value is visible on `dataOut` during the read cycle.
- R6: Read mode means `statusSel`=0 and `writeSel`=0. Outside read mode, `fluxPulse`, `hostRead` and elapsed time have no effect, and the timer, the shifter and `dataOut` hold their values.
- R7: If a pulse arrives in the same cycle a timeout is due, only a 1 is shifted.
- R8: Reset (`rstN` low, asynchronous) clears the shifter, the data register and the bit timer.
- R9: If `cellSel` changes to a shorter length while the timer is already at or beyond the new limit of L+1, a 0 is shifted at the next read-mode edge.
- R10: If a byte completes at the same edge as a clearing host read, the register takes the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusSel | input | 1 | Mode switch line; must be 0 for read mode |
| writeSel | input | 1 | Mode switch line; must be 0 for read mode |
| cellSel | input | 2 | Bit-cell length code |
| fluxPulse | input | 1 | One-cycle flux transition from the drive |
| hostRead | input | 1 | Host read strobe of the data register |
| dataOut | output | 8 | Data register contents |

## Verification
The assertions assume that `fluxPulse` and `hostRead` are synchronous to `clk`. They also assume that each strobe counts once per high cycle. The bound check on the bit timer further assumes that `cellSel` is held steady for at least one read-mode edge before it is relied on.

The stimulus drives all inputs only on falling edges, one value per cycle. It changes `cellSel` only at occasional random points, and the directed cases set up each length switch explicitly. The random stretches mix sparse pulses, long silences, mode toggles and stray host reads. This keeps the random runs inside those assumptions.

// File: rtl/fluxrd_pkg.sv
package fluxrd_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;    // one bit enters the shifter this edge
    logic shiftBit;   // value of that bit
    logic clearData;  // host consumed a complete byte
  } fluxrd_strb_t;

endpackage

// File: rtl/fluxrd_ctrl.sv
module fluxrd_ctrl
  import fluxrd_pkg::*;
#(
  parameter int LEN_C0 = 24,
  parameter int LEN_C1 = 12,
  parameter int LEN_C2 = 32,
  parameter int LEN_C3 = 16,
  parameter int CNT_W  = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         readMode,
  input  logic [1:0]   cellSel,
  input  logic         fluxPulse,
  input  logic         hostRead,
  input  logic         dataFull,
  output fluxrd_strb_t strb
);

  logic [CNT_W-1:0] cellCnt;
  logic [CNT_W-1:0] cellLimit;
  logic             timeoutDue;

  // Limit is L+1: the timeout fires on the (L+2)th cycle after a shift (R1, R3).
  always_comb begin
    unique case (cellSel)
      2'd0:    cellLimit = CNT_W'(LEN_C0 + 1);
      2'd1:    cellLimit = CNT_W'(LEN_C1 + 1);
      2'd2:    cellLimit = CNT_W'(LEN_C2 + 1);
      default: cellLimit = CNT_W'(LEN_C3 + 1);
    endcase
  end

  // A >= compare lets a shortened length fire at once (R9).
  assign timeoutDue = (cellCnt >= cellLimit);

  always_comb begin
    strb.shiftEn   = readMode && (fluxPulse || timeoutDue);
    strb.shiftBit  = fluxPulse;  // pulse takes priority over timeout (R7)
    strb.clearData = readMode && hostRead && dataFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt <= '0;
    end else if (readMode) begin
      if (fluxPulse || timeoutDue) cellCnt <= '0;
      else                         cellCnt <= cellCnt + 1'b1;
    end
  end

  p_flux_restart_r2 : assert property (@(posedge clk) disable iff (!rstN)
    readMode && fluxPulse |=> cellCnt == '0);

  p_flux_wins_r7 : assert property (@(posedge clk) disable iff (!rstN)
    readMode && fluxPulse |-> strb.shiftEn && strb.shiftBit);

  p_cnt_bound_r3 : assert property (@(posedge clk) disable iff (!rstN)
    $past(readMode) && $stable(cellSel) |-> cellCnt <= cellLimit);

  p_idle_timer_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !readMode |=> $stable(cellCnt));

endmodule

// File: rtl/fluxrd_dp.sv
module fluxrd_dp
  import fluxrd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fluxrd_strb_t      strb,
  output logic [DATA_W-1:0] dataReg
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] shNext;
  logic              byteDone;

  assign shNext   = {shReg[DATA_W-2:0], strb.shiftBit};
  assign byteDone = strb.shiftEn && shNext[MSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      dataReg <= '0;
    end else begin
      if (strb.shiftEn) shReg <= byteDone ? '0 : shNext;
      // New byte overrides a clearing read in the same cycle (R10).
      if (byteDone)            dataReg <= shNext;
      else if (strb.clearData) dataReg <= '0;
    end
  end

  p_capture_clears_r4 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReg[MSB]) |-> shReg == '0);

  p_shift_msb_low_r4 : assert property (@(posedge clk) disable iff (!rstN)
    !shReg[MSB]);

  p_clear_r5 : assert property (@(posedge clk) disable iff (!rstN)
    strb.clearData && !strb.shiftEn |=> dataReg == '0);

endmodule

// File: rtl/fluxrd_top.sv
module fluxrd_top
  import fluxrd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_C0 = 24,
  parameter int LEN_C1 = 12,
  parameter int LEN_C2 = 32,
  parameter int LEN_C3 = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              statusSel,
  input  logic              writeSel,
  input  logic [1:0]        cellSel,
  input  logic              fluxPulse,
  input  logic              hostRead,
  output logic [DATA_W-1:0] dataOut
);

  localparam int MAX_LEN_A = (LEN_C0 > LEN_C1) ? LEN_C0 : LEN_C1;
  localparam int MAX_LEN_B = (LEN_C2 > LEN_C3) ? LEN_C2 : LEN_C3;
  localparam int MAX_LEN   = (MAX_LEN_A > MAX_LEN_B) ? MAX_LEN_A : MAX_LEN_B;
  localparam int CNT_W     = $clog2(MAX_LEN + 2) + 1;

  logic         readMode;
  fluxrd_strb_t strb;

  assign readMode = !statusSel && !writeSel;

  fluxrd_ctrl #(
    .LEN_C0(LEN_C0), .LEN_C1(LEN_C1), .LEN_C2(LEN_C2), .LEN_C3(LEN_C3),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .readMode (readMode),
    .cellSel  (cellSel),
    .fluxPulse(fluxPulse),
    .hostRead (hostRead),
    .dataFull (dataOut[DATA_W-1]),
    .strb     (strb)
  );

  fluxrd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dataReg(dataOut)
  );

  p_hold_outside_r6 : assert property (@(posedge clk) disable iff (!rstN)
    !readMode |=> $stable(dataOut));

  p_read_consumes_r5 : assert property (@(posedge clk) disable iff (!rstN)
    readMode && hostRead && dataOut[DATA_W-1] |=> dataOut == '0 || dataOut[DATA_W-1]);

  p_full_or_empty_r4 : assert property (@(posedge clk) disable iff (!rstN)
    dataOut == '0 || dataOut[DATA_W-1]);

  p_reset_r8 : assert property (@(posedge clk)
    !rstN |-> dataOut == '0);

endmodule

// File: tb/fluxrd_top_tb.sv
module fluxrd_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       statusSel = 1'b0;
  logic       writeSel = 1'b0;
  logic [1:0] cellSel = 2'd0;
  logic       fluxPulse = 1'b0;
  logic       hostRead = 1'b0;
  logic [7:0] dataOut;

  int checks = 0;
  int failures = 0;

  // Reference model state
  int         mCnt = 0;
  logic [7:0] mSh = '0;
  logic [7:0] mData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fluxrd_top u_dut (
    .clk(clk), .rstN(rstN), .statusSel(statusSel), .writeSel(writeSel),
    .cellSel(cellSel), .fluxPulse(fluxPulse), .hostRead(hostRead),
    .dataOut(dataOut)
  );

  // Cell length table from R1.
  function automatic int cellLen(input logic [1:0] c);
    case (c)
      2'd0: return 24;
      2'd1: return 12;
      2'd2: return 32;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Next-state of the reference model for one edge (R2..R7, R9, R10).
  task automatic modelStep(input logic fl, input logic hr, input logic rm, input logic [1:0] cs);
    logic [7:0] nxt;
    logic       shiftNow, done, tOut;
    tOut = (mCnt >= cellLen(cs) + 1);
    shiftNow = rm && (fl || tOut);
    nxt = {mSh[6:0], fl};
    done = shiftNow && nxt[7];
    if (rm) mCnt = (fl || tOut) ? 0 : mCnt + 1;
    if (shiftNow) mSh = done ? 8'h00 : nxt;
    if (done) mData = nxt;
    else if (rm && hr && mData[7]) mData = 8'h00;
  endtask

  // Drive one cycle at the falling edge and check at the next falling edge.
  task automatic cyc(input logic fl, input logic hr, input logic ss, input logic ws,
                     input logic [1:0] cs, input string tag);
    fluxPulse = fl; hostRead = hr; statusSel = ss; writeSel = ws; cellSel = cs;
    modelStep(fl, hr, !ss && !ws, cs);
    @(posedge clk);
    @(negedge clk);
    chk(tag, dataOut, mData);
  endtask

  task automatic idle(input int n, input logic [1:0] cs, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, cs, tag);
  endtask

  task automatic doReset();
    fluxPulse = 0; hostRead = 0; statusSel = 0; writeSel = 0;
    rstN = 1'b0;
    mCnt = 0; mSh = '0; mData = '0;
    @(posedge clk);
    @(negedge clk);
    chk("R8", dataOut, 8'h00);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    int p;
    logic [7:0] held;
    seed = 32'd20190613;
    void'($urandom(seed));
    @(negedge clk);
    doReset();

    // R1/R3: one pulse, then silence, for each cell code.
    for (int c = 0; c < 4; c++) begin
      doReset();
      p = cellLen(2'(c)) + 2;
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'(c), "R2");
      idle(7 * p - 1, 2'(c), "R3");
      chk("R3", dataOut, 8'h00);
      idle(1, 2'(c), "R1");
      chk("R1", dataOut, 8'h80);
    end

    // R5: the byte is visible during the read, then cleared.
    chk("R5", dataOut, 8'h80);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'd3, "R5");
    chk("R5", dataOut, 8'h00);

    // R7: pulse in the cycle a timeout is due.
    doReset();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd3, "R2");
    idle(17, 2'd3, "R7");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd3, "R7");
    idle(6 * 18, 2'd3, "R7");
    chk("R7", dataOut, 8'hC0);

    // R6: outside read mode, pulses, reads and time change nothing.
    held = dataOut;
    for (int i = 0; i < 200; i++)
      cyc(i[0], i[1], 1'b1, i[2], 2'd1, "R6");
    chk("R6", dataOut, held);
    for (int i = 0; i < 50; i++)
      cyc(i[0], i[1], 1'b0, 1'b1, 2'd1, "R6");
    chk("R6", dataOut, held);

    // R9: shorten the cell while the timer is past the new limit.
    doReset();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd2, "R9");
    idle(20, 2'd2, "R9");
    idle(84, 2'd1, "R9");
    chk("R9", dataOut, 8'h00);
    idle(1, 2'd1, "R9");
    chk("R9", dataOut, 8'h80);

    // R10: a byte completes at the same edge as a clearing read.
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, "R10");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, "R10");
    idle(6 * 14 - 1, 2'd1, "R10");
    chk("R10", dataOut, 8'h80);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'd1, "R10");
    chk("R10", dataOut, 8'hC0);

    // Random mix checked against the model (R4 framing throughout).
    doReset();
    begin
      logic [1:0] cs;
      cs = 2'd1;
      for (int i = 0; i < 6000; i++) begin
        logic fl, hr, ss, ws;
        if ($urandom_range(0, 199) == 0) cs = 2'($urandom_range(0, 3));
        fl = ($urandom_range(0, 9) == 0);
        hr = ($urandom_range(0, 11) == 0);
        ss = ($urandom_range(0, 19) == 0);
        ws = ($urandom_range(0, 29) == 0);
        cyc(fl, hr, ss, ws, cs, "R4");
      end
    end

    // R8: reset in the middle of activity.
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, "R2");
    doReset();
    chk("R8", dataOut, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule